// File: doc/BRIEF.md
# Segmented Address Extender

This block widens 32-bit logical addresses issued by a processor core into 36-bit physical addresses. A bank of programmable segments describes windows of logical space. Each window has an aligned base, a power-of-two length and a replacement page number. Each window also carries a permission byte that separates user and supervisor rights to read, write and execute. Software programs a segment by writing its two 32-bit words through a plain synchronous write port.

The lookup path is purely combinational. A logical address and an access type go in, and the 36-bit physical address, a hit flag and a fault flag come out in the same cycle. The lookup port is a plain control/data path with no valid/ready handshake and no back-pressure, because every address receives an answer at once. Segments may overlap. When several match, the one with the highest index decides both the translation and the permission check.

Top module: `lext_xlate`

## Requirements
- R1: After reset, segment 0 maps logical 0x0000_0000..0x7FFF_FFFF one-to-one with every right granted, and all other segments are disabled. A lookup below 0x8000_0000 therefore hits with paddr equal to the address zero-extended, and a lookup at or above 0x8000_0000 misses.
- R2: The high word of a segment holds the base page in bits [31:12] and a size code in bits [4:0]. The segment covers 2^(code+1) bytes, and a logical address matches when its bits above the segment size equal the same bits of the base.
- R3: The low word of a segment holds a 24-bit replacement page in bits [31:8] and the permission byte in bits [7:0].
- R4: On a hit, paddr equals the replacement page shifted left by 12, with every bit below the segment size taken from the logical address. Replacement bits that fall under the offset are ignored.
- R5: A segment whose size code is below 11 never matches.
- R6: When several segments match, the highest-numbered one supplies the translation and the permission check.
- R7: Permission bits: bit0 user read, bit1 user write, bit2 user execute, bit3 supervisor read, bit4 supervisor write, bit5 supervisor execute. Access kind encoding: 0 read, 1 write, 2 execute, 3 reserved. A reserved kind is always denied. A denied access by the winning segment gives fault=1, hit=0 and paddr=0.
- R8: When no segment matches, hit=0, fault=0 and paddr=0.
- R9: A configuration write changes the lookup result only after the next rising clock edge. cfg_hi_sel=1 selects the high word and 0 selects the low word.
- R10: hit and fault are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Segment word write enable |
| cfg_idx | input | 4 | Segment index to write |
| cfg_hi_sel | input | 1 | 1 writes the high word, 0 writes the low word |
| cfg_wdata | input | 32 | Word to write |
| lk_addr | input | 32 | Logical address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_sup | input | 1 | 1 for supervisor access, 0 for user access |
| lk_paddr | output | 36 | Physical address, zero unless hit |
| lk_hit | output | 1 | Translation succeeded |
| lk_fault | output | 1 | Matching segment denied the access |

## Verification
The bench builds the block with its defaults: sixteen segments, 32-bit logical and 36-bit physical addresses, 12-bit pages and a minimum size code of 11. With sixteen segments available, a three-deep overlap can be stacked (segments 0, 1 and 2) on the same logical page, so the highest-index rule is checked at each layer. The 36-bit width lets replacement pages land in the upper nibble. A 256 MB segment exercises offset merging far above the page bits, and a code-10 segment shows the disable threshold falling back to the reset identity map.

// File: rtl/lext_pkg.sv
package lext_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int unsigned PERM_W   = 8;
  localparam int unsigned RIGHTS_N = 3;

  // Index of the permission bit for one access; kind must not be ACC_RSVD.
  function automatic int unsigned perm_index(input logic sup, input logic [1:0] kind);
    return (sup ? RIGHTS_N : 0) + int'(kind);
  endfunction
endpackage

// File: rtl/lext_seg_regs.sv
module lext_seg_regs #(
  parameter int unsigned NUM_SEG   = 16,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned RST0_CODE = 30,
  parameter int unsigned PERM_ALL  = 255,
  localparam int unsigned IDX_W    = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              hi_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] hi_q [NUM_SEG],
  output logic [WORD_W-1:0] lo_q [NUM_SEG]
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [WORD_W-1:0] HI_RST = (s == 0) ? WORD_W'(RST0_CODE) : '0;
    localparam logic [WORD_W-1:0] LO_RST = (s == 0) ? WORD_W'(PERM_ALL)  : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[s] <= HI_RST;
        lo_q[s] <= LO_RST;
      end else if (we && idx == IDX_W'(s)) begin
        if (hi_sel) hi_q[s] <= wdata;
        else        lo_q[s] <= wdata;
      end
    end
  end
endmodule

// File: rtl/lext_seg_match.sv
module lext_seg_match #(
  parameter int unsigned LA_W     = 32,
  parameter int unsigned PA_W     = 36,
  parameter int unsigned PAGE_W   = 12,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned PERM_W   = 8,
  parameter int unsigned MIN_CODE = 11
) (
  input  logic [LA_W-1:0]   hi_word,
  input  logic [LA_W-1:0]   lo_word,
  input  logic [LA_W-1:0]   addr,
  output logic              match,
  output logic [PA_W-1:0]   paddr,
  output logic [PERM_W-1:0] perm
);
  logic [CODE_W-1:0] code;
  logic              enabled;
  logic              differ;

  assign code    = hi_word[CODE_W-1:0];
  assign enabled = int'(code) >= int'(MIN_CODE);
  assign perm    = lo_word[PERM_W-1:0];

  always_comb begin
    differ = 1'b0;
    for (int i = PAGE_W; i < LA_W; i++) begin
      if (i > int'(code) && (addr[i] != hi_word[i])) differ = 1'b1;
    end
  end

  assign match = enabled && !differ;

  always_comb begin
    paddr = '0;
    for (int j = 0; j < PA_W; j++) begin
      if (j < PAGE_W)                          paddr[j] = addr[j];
      else if (j < LA_W && j <= int'(code))    paddr[j] = addr[j];
      else                                     paddr[j] = lo_word[PERM_W + j - PAGE_W];
    end
  end
endmodule

// File: rtl/lext_prio.sv
module lext_prio #(
  parameter int unsigned NUM_SEG = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   win
);
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (req[s]) begin
        any = 1'b1;
        win = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/lext_xlate.sv
module lext_xlate #(
  parameter int unsigned NUM_SEG  = 16,
  parameter int unsigned LA_W     = 32,
  parameter int unsigned PA_W     = 36,
  parameter int unsigned PAGE_W   = 12,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned MIN_CODE = 11,
  localparam int unsigned IDX_W   = $clog2(NUM_SEG),
  localparam int unsigned PERM_W  = lext_pkg::PERM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_hi_sel,
  input  logic [LA_W-1:0]  cfg_wdata,
  input  logic [LA_W-1:0]  lk_addr,
  input  logic [1:0]       lk_kind,
  input  logic             lk_sup,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_hit,
  output logic             lk_fault
);
  import lext_pkg::*;

  logic [LA_W-1:0]   hi_q [NUM_SEG];
  logic [LA_W-1:0]   lo_q [NUM_SEG];
  logic [NUM_SEG-1:0] seg_hit;
  logic [PA_W-1:0]   seg_pa   [NUM_SEG];
  logic [PERM_W-1:0] seg_perm [NUM_SEG];
  logic              any_hit;
  logic [IDX_W-1:0]  win;
  logic [PERM_W-1:0] win_perm;
  logic              allowed;

  lext_seg_regs #(
    .NUM_SEG(NUM_SEG), .WORD_W(LA_W), .RST0_CODE(LA_W - 2), .PERM_ALL((1 << PERM_W) - 1)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .hi_sel(cfg_hi_sel),
    .wdata(cfg_wdata), .hi_q(hi_q), .lo_q(lo_q)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_cmp
    lext_seg_match #(
      .LA_W(LA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .CODE_W(CODE_W),
      .PERM_W(PERM_W), .MIN_CODE(MIN_CODE)
    ) u_cmp (
      .hi_word(hi_q[s]), .lo_word(lo_q[s]), .addr(lk_addr),
      .match(seg_hit[s]), .paddr(seg_pa[s]), .perm(seg_perm[s])
    );
  end

  lext_prio #(.NUM_SEG(NUM_SEG)) u_prio (.req(seg_hit), .any(any_hit), .win(win));

  assign win_perm = seg_perm[win];

  always_comb begin
    if (lk_kind == ACC_RSVD) allowed = 1'b0;
    else                     allowed = win_perm[perm_index(lk_sup, lk_kind)];
  end

  assign lk_hit   = any_hit && allowed;
  assign lk_fault = any_hit && !allowed;
  assign lk_paddr = lk_hit ? seg_pa[win] : '0;
endmodule

// File: rtl/lext_xlate_chk.sv
module lext_xlate_chk #(
  parameter int unsigned LA_W = 32,
  parameter int unsigned PA_W = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [LA_W-1:0] lk_addr,
  input logic [1:0]      lk_kind,
  input logic [PA_W-1:0] lk_paddr,
  input logic            lk_hit,
  input logic            lk_fault
);
  logic cfg_touched;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_touched <= 1'b0;
    else if (cfg_we) cfg_touched <= 1'b1;
  end

  // R10
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_paddr == '0);

  // R4
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[11:0] == lk_addr[11:0]);

  // R1
  reset_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_touched && !lk_addr[LA_W-1] && lk_kind != 2'd3)
      |-> (lk_hit && lk_paddr == PA_W'(lk_addr)));

  // R1
  reset_upper_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_touched && lk_addr[LA_W-1]) |-> (!lk_hit && !lk_fault));
endmodule

bind lext_xlate lext_xlate_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .lk_addr(lk_addr), .lk_kind(lk_kind),
  .lk_paddr(lk_paddr), .lk_hit(lk_hit), .lk_fault(lk_fault)
);

// File: tb/tb_lext_xlate.sv
module tb_lext_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_hi_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_sup = 1'b0;
  logic [35:0] lk_paddr;
  logic        lk_hit, lk_fault;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lext_xlate dut (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  kind;
    logic        sup;
    logic        hit;
    logic        fault;
    logic [35:0] pa;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h2100_0ABC, 2'd0, 1'b0, 1'b1, 1'b0, 36'h1_0000_0ABC, 4'd6},  // R6 seg2 over 1 and 0
    '{32'h2100_1234, 2'd0, 1'b0, 1'b1, 1'b0, 36'h2_0000_1234, 4'd4},  // R4 low repl bits ignored
    '{32'h2100_0FFF, 2'd1, 1'b1, 1'b1, 1'b0, 36'h1_0000_0FFF, 4'd2},  // R2 top of 4 KB
    '{32'h2100_0ABC, 2'd2, 1'b1, 1'b1, 1'b0, 36'h1_0000_0ABC, 4'd3},  // R3 perm 0xFF
    '{32'h3000_1F00, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_00AB_DF00, 4'd4},  // R4 8 KB merge
    '{32'h3000_1F00, 2'd1, 1'b0, 1'b0, 1'b1, 36'h0,           4'd7},  // R7 user write denied
    '{32'h3000_1F00, 2'd0, 1'b1, 1'b0, 1'b1, 36'h0,           4'd7},  // R7 sup read denied
    '{32'h3000_2000, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_3000_2000, 4'd2},  // R2 just past 8 KB
    '{32'h4000_0010, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_4000_0010, 4'd5},  // R5 code 10 disabled
    '{32'hF000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 36'h0,           4'd8},  // R8 no match
    '{32'h9ABC_DEF0, 2'd0, 1'b1, 1'b1, 1'b0, 36'h8_0ABC_DEF0, 4'd3},  // R3 256 MB sup only
    '{32'h9ABC_DEF0, 2'd0, 1'b0, 1'b0, 1'b1, 36'h0,           4'd7},  // R7 user denied
    '{32'h2100_0ABC, 2'd3, 1'b0, 1'b0, 1'b1, 36'h0,           4'd7},  // R7 reserved kind
    '{32'h2100_F000, 2'd1, 1'b0, 1'b1, 1'b0, 36'h2_0000_F000, 4'd6}   // R6 seg1 over seg0
  };

  task automatic compare(input string req, input logic eh, input logic ef, input logic [35:0] ep);
    checks++;
    if (lk_hit !== eh || lk_fault !== ef || lk_paddr !== ep) begin
      errors++;
      $display("FAIL %s addr=%h: got hit=%b fault=%b pa=%h, expected hit=%b fault=%b pa=%h",
               req, lk_addr, lk_hit, lk_fault, lk_paddr, eh, ef, ep);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic [1:0] k, input logic s,
                       input string req, input logic eh, input logic ef, input logic [35:0] ep);
    @(negedge clk);
    lk_addr = a; lk_kind = k; lk_sup = s;
    #1;
    compare(req, eh, ef, ep);
  endtask

  task automatic wr(input logic [3:0] idx, input logic hi, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_hi_sel = hi; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset map
    probe(32'h1234_5678, 2'd0, 1'b0, "R1", 1'b1, 1'b0, 36'h0_1234_5678);
    probe(32'h7FFF_FFFF, 2'd2, 1'b1, "R1", 1'b1, 1'b0, 36'h0_7FFF_FFFF);
    probe(32'h8000_0000, 2'd0, 1'b0, "R1", 1'b0, 1'b0, 36'h0);
    probe(32'h2100_0ABC, 2'd0, 1'b0, "R1", 1'b1, 1'b0, 36'h0_2100_0ABC);

    wr(4'd1,  1'b1, 32'h2100_000F); wr(4'd1,  1'b0, 32'h2000_0FFF);
    wr(4'd2,  1'b1, 32'h2100_000B); wr(4'd2,  1'b0, 32'h1000_00FF);
    wr(4'd7,  1'b1, 32'h3000_000C); wr(4'd7,  1'b0, 32'h000A_BC01);
    wr(4'd9,  1'b1, 32'h4000_000A); wr(4'd9,  1'b0, 32'h0000_00FF);
    wr(4'd12, 1'b1, 32'h9000_001B); wr(4'd12, 1'b0, 32'h8000_0038);

    for (int v = 0; v < NV; v++)
      probe(VEC[v].addr, VEC[v].kind, VEC[v].sup, $sformatf("R%0d", VEC[v].req),
            VEC[v].hit, VEC[v].fault, VEC[v].pa);

    // R9 write is not visible before the clock edge, then is
    @(negedge clk);
    lk_addr = 32'h2100_0ABC; lk_kind = 2'd0; lk_sup = 1'b0;
    cfg_we = 1'b1; cfg_idx = 4'd2; cfg_hi_sel = 1'b0; cfg_wdata = 32'h1000_0000;
    #1;
    compare("R9", 1'b1, 1'b0, 36'h1_0000_0ABC);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    compare("R9", 1'b0, 1'b1, 36'h0);
    // R6 fault from winner does not fall back to a lower segment
    probe(32'h2100_0ABC, 2'd1, 1'b1, "R6", 1'b0, 1'b1, 36'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule